// File: doc/BRIEF.md
# Watermark Stop/Go Link Flow Control

This block sits at the receiving end of a point-to-point phit link. Phits that arrive on the link are written into a buffer, and the next stage drains them in the order they arrived. The buffer fill level is compared against two configurable thresholds. When the level climbs to the upper threshold, the block sends one Stop symbol back toward the sender. When the level later sinks to the lower threshold, it sends one Go symbol. The gap between the two thresholds gives hysteresis, so the reverse channel is not flooded with symbols while the level wanders around one threshold.

The project also contains the sender-side gate that listens to these symbols. A source asserts a request every cycle it has a phit ready. The gate lets the phit out only while the link is open. A Stop closes the gate from the next cycle on, and a Go reopens it from the next cycle on. The phits already on the wire when Stop is issued are absorbed by the space above the upper threshold. As long as that space covers the loop latency, nothing is dropped, and the link simply blocks in place. Here the loop latency is the wire delay D plus two cycles: one for the registered symbol and one for the gate register.

The parameters are the phit width, the buffer depth and both thresholds. The lower threshold must be strictly below the upper one.

Top module: `stopgo_link`

## Requirements
- R1: After reset the buffer is empty (`out_valid` low), no flow-control symbol is being sent (`fc_valid` low), and the sender gate is open (`gate_launch` follows `gate_req`).
- R2: Every phit accepted from the link is presented on `out_phit`, with no loss, duplication or reordering. A phit leaves the buffer on each cycle where `out_valid` and `out_take` are both high.
- R3: Provided DEPTH minus HI_MARK is at least D+2, where D is the number of cycles a launched phit spends on the wire, the buffer never receives a phit while holding DEPTH entries. A sender that runs flat out against a stalled consumer, starting from empty, fills the buffer to exactly DEPTH.
- R4: While the link is in the Go state, the cycle after the occupancy is at or above HI_MARK, `fc_valid` pulses for one cycle with `fc_stop` = 1 (Stop), and the link enters the Stop state.
- R5: While the link is in the Stop state, the cycle after the occupancy is at or below LO_MARK, `fc_valid` pulses for one cycle with `fc_stop` = 0 (Go), and the link enters the Go state.
- R6: Symbols are sent only on a state change. While a state holds, no symbol is sent, and successive symbols alternate, starting with Stop.
- R7: `gate_launch` equals `gate_req` AND the gate's open state. A Stop seen on `gate_fc_valid`/`gate_fc_stop` closes the gate from the following cycle, and a Go reopens it from the following cycle.
- R8: `out_take` while the buffer is empty has no effect. `out_valid` stays low until a phit arrives, and that phit is the first one delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A phit arrives from the link this cycle |
| rx_phit | input | PHIT_W | Arriving phit |
| out_valid | output | 1 | Buffer holds at least one phit |
| out_phit | output | PHIT_W | Oldest buffered phit |
| out_take | input | 1 | Next stage takes the oldest phit |
| fc_valid | output | 1 | A flow-control symbol is sent upstream this cycle |
| fc_stop | output | 1 | Symbol value: 1 = Stop, 0 = Go |
| gate_fc_valid | input | 1 | Flow-control symbol arriving at the sender gate |
| gate_fc_stop | input | 1 | Value of that symbol: 1 = Stop, 0 = Go |
| gate_req | input | 1 | Source has a phit ready |
| gate_launch | output | 1 | Phit is launched onto the link this cycle |

## Verification
The bench closes the loop: the gate's launches travel through a D-stage wire model into the buffer, and the emitted symbols feed straight back to the gate.

Balanced random traffic keeps the occupancy moving around both thresholds, which separates correct hysteresis from symbols that repeat or fire at the wrong level. A load-heavy mix drives the link through repeated Stop cycles, which shows whether the phits still in flight are absorbed. A drain-heavy mix exercises the Go path and the empty-buffer cases.

In a directed full-stall run from empty, the drained phit count must equal DEPTH exactly. Fewer phits means the headroom arithmetic is off, and a drop or overflow shows up as an ordering mismatch.

// File: rtl/stopgo_pkg.sv
package stopgo_pkg;
    typedef enum logic {
        SYM_GO   = 1'b0,
        SYM_STOP = 1'b1
    } fc_sym_e;
endpackage

// File: rtl/link_fifo.sv
module link_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic          empty,
    output logic [CW-1:0] fill
);
    localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic     do_push, do_pop;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        s_d     = s_q;
        do_push = push && (s_q.cnt != DEPTH_C);
        do_pop  = pop && (s_q.cnt != '0);
        if (do_push) begin
            s_d.wr = (s_q.wr == LAST_C) ? '0 : s_q.wr + 1'b1;
        end
        if (do_pop) begin
            s_d.rd = (s_q.rd == LAST_C) ? '0 : s_q.rd + 1'b1;
        end
        s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[s_q.wr] <= push_data;
        end
    end

    assign pop_data = mem[s_q.rd];
    assign empty    = (s_q.cnt == '0);
    assign fill     = s_q.cnt;
endmodule

// File: rtl/wm_ctrl.sv
module wm_ctrl
    import stopgo_pkg::*;
#(
    parameter int CW = 5,
    parameter int HI = 10,
    parameter int LO = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] fill,
    output logic          sym_valid,
    output logic          sym_stop
);
    localparam logic [CW-1:0] HI_C = CW'(HI);
    localparam logic [CW-1:0] LO_C = CW'(LO);

    typedef struct packed {
        logic    stopped;
        logic    sv;
        fc_sym_e sym;
    } wm_st_t;

    wm_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sv = 1'b0;
        if (!s_q.stopped && (fill >= HI_C)) begin
            s_d.stopped = 1'b1;
            s_d.sv      = 1'b1;
            s_d.sym     = SYM_STOP;
        end else if (s_q.stopped && (fill <= LO_C)) begin
            s_d.stopped = 1'b0;
            s_d.sv      = 1'b1;
            s_d.sym     = SYM_GO;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{stopped: 1'b0, sv: 1'b0, sym: SYM_GO};
        end else begin
            s_q <= s_d;
        end
    end

    assign sym_valid = s_q.sv;
    assign sym_stop  = (s_q.sym == SYM_STOP);
endmodule

// File: rtl/tx_gate.sv
module tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic fc_valid,
    input  logic fc_stop,
    input  logic req,
    output logic launch
);
    typedef struct packed {
        logic open;
    } gate_st_t;

    gate_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fc_valid) begin
            s_d.open = !fc_stop;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{open: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign launch = req && s_q.open;
endmodule

// File: rtl/stopgo_link.sv
module stopgo_link #(
    parameter int PHIT_W  = 8,
    parameter int DEPTH   = 16,
    parameter int HI_MARK = 10,
    parameter int LO_MARK = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [PHIT_W-1:0] rx_phit,
    output logic              out_valid,
    output logic [PHIT_W-1:0] out_phit,
    input  logic              out_take,
    output logic              fc_valid,
    output logic              fc_stop,
    input  logic              gate_fc_valid,
    input  logic              gate_fc_stop,
    input  logic              gate_req,
    output logic              gate_launch
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          empty;
    logic [CW-1:0] fill;

    link_fifo #(.W(PHIT_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid),
        .push_data (rx_phit),
        .pop       (out_take),
        .pop_data  (out_phit),
        .empty     (empty),
        .fill      (fill)
    );

    wm_ctrl #(.CW(CW), .HI(HI_MARK), .LO(LO_MARK)) u_wm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill      (fill),
        .sym_valid (fc_valid),
        .sym_stop  (fc_stop)
    );

    tx_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .fc_valid (gate_fc_valid),
        .fc_stop  (gate_fc_stop),
        .req      (gate_req),
        .launch   (gate_launch)
    );

    assign out_valid = !empty;
endmodule

// File: rtl/stopgo_link_chk.sv
module stopgo_link_chk #(
    parameter int DEPTH = 16,
    parameter int HI    = 10,
    parameter int LO    = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          out_valid,
    input logic          fc_valid,
    input logic          fc_stop,
    input logic          gate_fc_valid,
    input logic          gate_fc_stop,
    input logic          gate_req,
    input logic          gate_launch,
    input logic [CW-1:0] fill
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] HI_C    = CW'(HI);
    localparam logic [CW-1:0] LO_C    = CW'(LO);

    logic last_stop_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_stop_q <= 1'b0;
        end else if (fc_valid) begin
            last_stop_q <= fc_stop;
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (fill < DEPTH_C));

    a_r4_stop_at_high: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_valid && fc_stop) |-> ($past(fill) >= HI_C));

    a_r5_go_at_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_valid && !fc_stop) |-> ($past(fill) <= LO_C));

    a_r6_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        fc_valid |-> (fc_stop != last_stop_q));

    a_r7_gate_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_fc_valid && gate_fc_stop) |=> !gate_launch);

    a_r7_gate_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_fc_valid && !gate_fc_stop) |=> (gate_launch == gate_req));

    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !rx_valid) |=> !out_valid);
endmodule

bind stopgo_link stopgo_link_chk #(.DEPTH(DEPTH), .HI(HI_MARK), .LO(LO_MARK)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .out_valid     (out_valid),
    .fc_valid      (fc_valid),
    .fc_stop       (fc_stop),
    .gate_fc_valid (gate_fc_valid),
    .gate_fc_stop  (gate_fc_stop),
    .gate_req      (gate_req),
    .gate_launch   (gate_launch),
    .fill          (fill)
);

// File: tb/tb_stopgo_link.sv
module tb_stopgo_link;
    localparam int W = 8, DEPTH = 16, HI = 10, LO = 4, D = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n, rx_valid, out_take, gate_req;
    logic [W-1:0] rx_phit, out_phit;
    logic         out_valid, fc_valid, fc_stop, gate_launch;
    logic         gate_fc_valid, gate_fc_stop;

    assign gate_fc_valid = fc_valid;
    assign gate_fc_stop  = fc_stop;

    stopgo_link #(.PHIT_W(W), .DEPTH(DEPTH), .HI_MARK(HI), .LO_MARK(LO)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_phit(rx_phit),
        .out_valid(out_valid), .out_phit(out_phit), .out_take(out_take),
        .fc_valid(fc_valid), .fc_stop(fc_stop),
        .gate_fc_valid(gate_fc_valid), .gate_fc_stop(gate_fc_stop),
        .gate_req(gate_req), .gate_launch(gate_launch)
    );

    int checks = 0, fails = 0, pops = 0;
    bit done = 0;
    logic         pv [D];
    logic [W-1:0] pd [D];
    logic [W-1:0] expq [$];
    int   fill_now, fill_prev;
    bit   m_stopped, g_open, last_stop;
    logic [W-1:0] seq;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // 0 = no symbol, 1 = Stop, 2 = Go
    function automatic int exp_sym(input bit stopped, input int f);
        if (!stopped && f >= HI) return 1;
        if (stopped && f <= LO)  return 2;
        return 0;
    endfunction

    task automatic step(input int p_req, input int p_take);
        int e, nf;
        bit popped;
        @(negedge clk);
        e = exp_sym(m_stopped, fill_prev);
        if (e == 1)      chk(fc_valid && fc_stop, "R4", {fc_valid, fc_stop}, 3);
        else if (e == 2) chk(fc_valid && !fc_stop, "R5", {fc_valid, fc_stop}, 2);
        else             chk(!fc_valid, "R6", fc_valid, 0);
        if (fc_valid) begin
            chk(fc_stop != last_stop, "R6", fc_stop, !last_stop);
            last_stop = fc_stop;
        end
        if (e == 1) m_stopped = 1;
        if (e == 2) m_stopped = 0;

        gate_req = ($urandom_range(99) < p_req);
        out_take = ($urandom_range(99) < p_take);
        rx_valid = pv[D-1];
        rx_phit  = pd[D-1];
        #1;
        chk(out_valid == (fill_now != 0), "R8", out_valid, fill_now != 0);
        chk(gate_launch == (gate_req && g_open), "R7", gate_launch, gate_req && g_open);
        popped = out_valid && out_take;
        if (popped) begin
            pops++;
            if (expq.size() == 0) chk(0, "R2", out_phit, -1);
            else begin
                chk(out_phit == expq[0], "R2", out_phit, expq[0]);
                void'(expq.pop_front());
            end
        end
        if (fc_valid) g_open = !fc_stop;
        if (gate_launch) expq.push_back(seq);
        for (int i = D - 1; i > 0; i--) begin
            pv[i] = pv[i-1];
            pd[i] = pd[i-1];
        end
        pv[0] = gate_launch;
        pd[0] = seq;
        if (gate_launch) seq = seq + 1'b1;
        if (rx_valid) chk(fill_now < DEPTH, "R3", fill_now, DEPTH - 1);
        nf = fill_now + ((rx_valid && fill_now < DEPTH) ? 1 : 0) - (popped ? 1 : 0);
        fill_prev = fill_now;
        fill_now  = nf;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 0; rx_valid = 0; rx_phit = '0; out_take = 0; gate_req = 0;
        for (int i = 0; i < D; i++) begin pv[i] = 0; pd[i] = '0; end
        fill_now = 0; fill_prev = 0; m_stopped = 0; g_open = 1; last_stop = 0; seq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        gate_req = 1;
        #1;
        chk(!out_valid, "R1", out_valid, 0);
        chk(!fc_valid, "R1", fc_valid, 0);
        chk(gate_launch, "R1", gate_launch, 1);
        gate_req = 0;
        #1;
        chk(!gate_launch, "R1", gate_launch, 0);

        repeat (5) step(0, 100);           // R8: take on empty
        step(100, 0);                      // one phit enters the wire
        repeat (8) step(0, 0);
        repeat (6) step(0, 100);           // R8: that phit is delivered first
        repeat (3000) step(60, 50);
        repeat (60) step(0, 100);
        pops = 0;
        repeat (300) step(100, 0);         // R3: full stall from empty
        repeat (60) step(0, 100);
        chk(pops == DEPTH, "R3", pops, DEPTH);
        repeat (2000) step(90, 30);
        repeat (2000) step(30, 90);
        repeat (2000) step(70, 70);
        repeat (80) step(0, 100);
        chk(expq.size() == 0, "R2", expq.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule